// File: doc/BRIEF.md
# Dual-Port RAM with Mailbox Doorbells

This block is a synchronous true dual-port word memory. Each side, called left and right, has its own enable, write enable, output enable, upper and lower byte enables, address, write data and registered read data. The two sides can read or write any word in the same clock cycle.

The two highest addresses are also doorbells. When the right side writes the word one below the top, the left side's interrupt rises. The left side drops it by reading that word. The top word works the same way with the sides swapped. A per-side busy input comes from an outside arbiter and blocks that side's doorbell accesses from changing a flag. Data storage ignores busy. Both mailbox words hold data like any other location.

Top module: `dpram_mailbox`

## Requirements
- R1: A write occurs on a side when its enable and write enable are both high. It stores the upper lane (bits 15:8) when the upper byte enable is high and the lower lane (bits 7:0) when the lower byte enable is high. Each lane is selected independently.
- R2: A read occurs when enable and output enable are high and write enable is low. Its data appears on the read data port one clock after the address is presented. A lane whose byte enable is low reads as zero. When no read occurs, or both byte enables are low, the read data is all zero.
- R3: If one side reads a word in the same cycle that the other side writes it, the read returns the value held before the write.
- R4: A right-side write to address DEPTH-2 (0xFFE at the default size) sets the left interrupt in the following cycle.
- R5: A left-side access to address DEPTH-2 with enable and output enable high clears the left interrupt in the following cycle, whatever the level of write enable.
- R6: A left-side write to address DEPTH-1 (0xFFF) sets the right interrupt. A right-side access to DEPTH-1 with enable and output enable high clears it.
- R7: With enable low or write enable low, nothing is stored and no interrupt is set.
- R8: While the busy input of the side making a set or clear access is high, that access leaves the flag unchanged. The data is still stored.
- R9: If a set and a clear of the same flag happen in the same cycle, the flag ends up set.
- R10: The words at DEPTH-2 and DEPTH-1 store and return data like any other address.
- R11: Reset clears both interrupts and both read data registers. Interrupts are active high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| l_en | input | 1 | Left enable |
| l_we | input | 1 | Left write enable |
| l_oe | input | 1 | Left output enable |
| l_ub | input | 1 | Left upper byte enable |
| l_lb | input | 1 | Left lower byte enable |
| l_addr | input | ADDR_W | Left address |
| l_wdata | input | DATA_W | Left write data |
| l_busy | input | 1 | Left busy from the arbiter |
| l_rdata | output | DATA_W | Left read data, registered |
| l_irq | output | 1 | Left interrupt |
| r_en | input | 1 | Right enable |
| r_we | input | 1 | Right write enable |
| r_oe | input | 1 | Right output enable |
| r_ub | input | 1 | Right upper byte enable |
| r_lb | input | 1 | Right lower byte enable |
| r_addr | input | ADDR_W | Right address |
| r_wdata | input | DATA_W | Right write data |
| r_busy | input | 1 | Right busy from the arbiter |
| r_rdata | output | DATA_W | Right read data, registered |
| r_irq | output | 1 | Right interrupt |

## Verification
The bench builds the block with ADDR_W = 6 and DATA_W = 16, which gives 64 words with the doorbells at 62 and 63. At that size a random address lands on a mailbox often. Biased random traffic can then produce same-cycle set and clear, busy-gated doorbell accesses, and a read of a word the other side is writing, many times over. Directed steps cover each of these cases once on a known memory image.

// File: rtl/dpm_pkg.sv
package dpm_pkg;

    typedef struct packed {
        logic flag;
    } bell_state_t;

    typedef struct packed {
        logic set_l;
        logic clr_l;
        logic set_r;
        logic clr_r;
    } bell_req_t;

endpackage

// File: rtl/dpm_storage.sv
module dpm_storage #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_en,
    input  logic              a_we,
    input  logic              a_oe,
    input  logic [1:0]        a_be,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DATA_W-1:0] a_wdata,
    output logic [DATA_W-1:0] a_rdata,
    input  logic              b_en,
    input  logic              b_we,
    input  logic              b_oe,
    input  logic [1:0]        b_be,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [DATA_W-1:0] b_wdata,
    output logic [DATA_W-1:0] b_rdata
);
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int LANES  = 2;
    localparam int LANE_W = DATA_W / LANES;

    logic a_wr, a_rd, b_wr, b_rd;
    assign a_wr = a_en & a_we;
    assign b_wr = b_en & b_we;
    assign a_rd = a_en & ~a_we & a_oe;
    assign b_rd = b_en & ~b_we & b_oe;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] bank [DEPTH];
        logic [LANE_W-1:0] a_rd_d, a_rd_q, b_rd_d, b_rd_q;

        always_comb begin
            a_rd_d = (a_rd && a_be[g]) ? bank[a_addr] : '0;
            b_rd_d = (b_rd && b_be[g]) ? bank[b_addr] : '0;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                a_rd_q <= '0;
                b_rd_q <= '0;
            end else begin
                a_rd_q <= a_rd_d;
                b_rd_q <= b_rd_d;
            end
        end

        always_ff @(posedge clk) begin
            if (a_wr && a_be[g]) bank[a_addr] <= a_wdata[g*LANE_W +: LANE_W];
            if (b_wr && b_be[g]) bank[b_addr] <= b_wdata[g*LANE_W +: LANE_W];
        end

        assign a_rdata[g*LANE_W +: LANE_W] = a_rd_q;
        assign b_rdata[g*LANE_W +: LANE_W] = b_rd_q;

        assert_idle_lane_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
            !(a_rd && a_be[g]) |=> (a_rdata[g*LANE_W +: LANE_W] == '0));
        assert_idle_lane_zero_b_R2: assert property (@(posedge clk) disable iff (!rst_n)
            !(b_rd && b_be[g]) |=> (b_rdata[g*LANE_W +: LANE_W] == '0));
    end

endmodule

// File: rtl/dpm_doorbell.sv
module dpm_doorbell
    import dpm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    input  logic clr_req,
    output logic irq
);
    bell_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (set_req)
            state_d.flag = 1'b1;
        else if (clr_req)
            state_d.flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign irq = state_q.flag;

    assert_set_raises_R4: assert property (@(posedge clk) disable iff (!rst_n)
        set_req |=> irq);
    assert_clear_drops_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !set_req) |=> !irq);
    assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (set_req && clr_req) |=> irq);
    assert_hold_when_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_req && !clr_req) |=> $stable(irq));
    assert_reset_clear_R11: assert property (@(posedge clk)
        !rst_n |=> !irq);

endmodule

// File: rtl/dpram_mailbox.sv
module dpram_mailbox
    import dpm_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_en,
    input  logic              l_we,
    input  logic              l_oe,
    input  logic              l_ub,
    input  logic              l_lb,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    input  logic              l_busy,
    output logic [DATA_W-1:0] l_rdata,
    output logic              l_irq,
    input  logic              r_en,
    input  logic              r_we,
    input  logic              r_oe,
    input  logic              r_ub,
    input  logic              r_lb,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_wdata,
    input  logic              r_busy,
    output logic [DATA_W-1:0] r_rdata,
    output logic              r_irq
);
    localparam int                DEPTH  = 1 << ADDR_W;
    localparam logic [ADDR_W-1:0] BOX_L  = ADDR_W'(DEPTH - 2);
    localparam logic [ADDR_W-1:0] BOX_R  = ADDR_W'(DEPTH - 1);

    bell_req_t req;

    always_comb begin
        req.set_l = r_en & r_we & (r_addr == BOX_L) & ~r_busy;
        req.clr_l = l_en & l_oe & (l_addr == BOX_L) & ~l_busy;
        req.set_r = l_en & l_we & (l_addr == BOX_R) & ~l_busy;
        req.clr_r = r_en & r_oe & (r_addr == BOX_R) & ~r_busy;
    end

    dpm_storage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_storage (
        .clk    (clk),
        .rst_n  (rst_n),
        .a_en   (l_en),
        .a_we   (l_we),
        .a_oe   (l_oe),
        .a_be   ({l_ub, l_lb}),
        .a_addr (l_addr),
        .a_wdata(l_wdata),
        .a_rdata(l_rdata),
        .b_en   (r_en),
        .b_we   (r_we),
        .b_oe   (r_oe),
        .b_be   ({r_ub, r_lb}),
        .b_addr (r_addr),
        .b_wdata(r_wdata),
        .b_rdata(r_rdata)
    );

    dpm_doorbell i_bell_l (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_req(req.set_l),
        .clr_req(req.clr_l),
        .irq    (l_irq)
    );

    dpm_doorbell i_bell_r (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_req(req.set_r),
        .clr_req(req.clr_r),
        .irq    (r_irq)
    );

    assert_busy_blocks_l_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (r_busy && l_busy) |=> $stable(l_irq));
    assert_busy_blocks_r_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (r_busy && l_busy) |=> $stable(r_irq));
    assert_no_write_no_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!(r_en && r_we) && !l_irq) |=> !l_irq);

endmodule

// File: tb/test_dpram_mailbox.sv
`timescale 1ns/1ps
module test_dpram_mailbox;
    localparam int AW = 6;
    localparam int DW = 16;
    localparam int DEPTH = 1 << AW;
    localparam logic [AW-1:0] BOX_L = AW'(DEPTH - 2);
    localparam logic [AW-1:0] BOX_R = AW'(DEPTH - 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic l_en, l_we, l_oe, l_ub, l_lb, l_busy;
    logic r_en, r_we, r_oe, r_ub, r_lb, r_busy;
    logic [AW-1:0] l_addr, r_addr;
    logic [DW-1:0] l_wdata, r_wdata, l_rdata, r_rdata;
    logic l_irq, r_irq;

    always #2 clk = ~clk;

    dpram_mailbox #(.ADDR_W(AW), .DATA_W(DW)) i_dpram_mailbox (
        .clk(clk), .rst_n(rst_n),
        .l_en(l_en), .l_we(l_we), .l_oe(l_oe), .l_ub(l_ub), .l_lb(l_lb),
        .l_addr(l_addr), .l_wdata(l_wdata), .l_busy(l_busy),
        .l_rdata(l_rdata), .l_irq(l_irq),
        .r_en(r_en), .r_we(r_we), .r_oe(r_oe), .r_ub(r_ub), .r_lb(r_lb),
        .r_addr(r_addr), .r_wdata(r_wdata), .r_busy(r_busy),
        .r_rdata(r_rdata), .r_irq(r_irq)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] exp_l_rd = '0, exp_r_rd = '0;
    logic exp_l_irq = 0, exp_r_irq = 0;

    task automatic chk(string tag, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] rd_val(logic en, logic we, logic oe, logic ub,
                                             logic lb, logic [DW-1:0] w);
        logic [DW-1:0] v = '0;
        if (en && !we && oe) begin
            if (ub) v[15:8] = w[15:8];
            if (lb) v[7:0]  = w[7:0];
        end
        return v;
    endfunction

    task automatic model_step();
        logic sl, cl, sr, cr;
        exp_l_rd = rd_val(l_en, l_we, l_oe, l_ub, l_lb, mem[l_addr]);
        exp_r_rd = rd_val(r_en, r_we, r_oe, r_ub, r_lb, mem[r_addr]);
        if (l_en && l_we) begin
            if (l_ub) mem[l_addr][15:8] = l_wdata[15:8];
            if (l_lb) mem[l_addr][7:0]  = l_wdata[7:0];
        end
        if (r_en && r_we) begin
            if (r_ub) mem[r_addr][15:8] = r_wdata[15:8];
            if (r_lb) mem[r_addr][7:0]  = r_wdata[7:0];
        end
        sl = r_en && r_we && r_addr == BOX_L && !r_busy;
        cl = l_en && l_oe && l_addr == BOX_L && !l_busy;
        sr = l_en && l_we && l_addr == BOX_R && !l_busy;
        cr = r_en && r_oe && r_addr == BOX_R && !r_busy;
        exp_l_irq = sl ? 1'b1 : (cl ? 1'b0 : exp_l_irq);
        exp_r_irq = sr ? 1'b1 : (cr ? 1'b0 : exp_r_irq);
    endtask

    task automatic idle_all();
        {l_en, l_we, l_oe, l_ub, l_lb, l_busy} = '0;
        {r_en, r_we, r_oe, r_ub, r_lb, r_busy} = '0;
        l_addr = '0; r_addr = '0; l_wdata = '0; r_wdata = '0;
    endtask

    task automatic cycle(string tag);
        model_step();
        @(posedge clk);
        @(negedge clk);
        chk(tag, "l_rdata", l_rdata, exp_l_rd);
        chk(tag, "r_rdata", r_rdata, exp_r_rd);
        chk(tag, "l_irq", {15'b0, l_irq}, {15'b0, exp_l_irq});
        chk(tag, "r_irq", {15'b0, r_irq}, {15'b0, exp_r_irq});
        idle_all();
    endtask

    task automatic lwrite(logic [AW-1:0] a, logic [DW-1:0] d, logic ub, logic lb);
        l_en = 1; l_we = 1; l_ub = ub; l_lb = lb; l_addr = a; l_wdata = d;
    endtask
    task automatic lread(logic [AW-1:0] a, logic ub, logic lb);
        l_en = 1; l_oe = 1; l_ub = ub; l_lb = lb; l_addr = a;
    endtask
    task automatic rwrite(logic [AW-1:0] a, logic [DW-1:0] d);
        r_en = 1; r_we = 1; r_ub = 1; r_lb = 1; r_addr = a; r_wdata = d;
    endtask
    task automatic rread(logic [AW-1:0] a);
        r_en = 1; r_oe = 1; r_ub = 1; r_lb = 1; r_addr = a;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R2 watchdog: actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        idle_all();
        repeat (3) @(negedge clk);
        // R11: reset state
        chk("R11", "l_irq", {15'b0, l_irq}, '0);
        chk("R11", "r_irq", {15'b0, r_irq}, '0);
        chk("R11", "l_rdata", l_rdata, '0);
        chk("R11", "r_rdata", r_rdata, '0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: fill every word, top word write also rings right doorbell
        for (int a = 0; a < DEPTH; a++) begin
            lwrite(AW'(a), DW'(a * 16'h0101) ^ 16'h5A3C, 1, 1);
            cycle("R1");
        end
        rread(BOX_R); cycle("R6");

        // R1: single-lane writes
        lwrite(5, 16'hAAAA, 1, 0); cycle("R1");
        lwrite(6, 16'hBBBB, 0, 1); cycle("R1");
        lread(5, 1, 1); cycle("R1");
        lread(6, 1, 1); cycle("R1");
        // R2: lane masking on read
        lread(6, 1, 0); cycle("R2");
        lread(6, 0, 1); cycle("R2");
        lread(6, 0, 0); cycle("R2");
        // R7: writes without enable or write enable
        lwrite(7, 16'h1234, 1, 1); l_en = 0; cycle("R7");
        l_en = 1; l_ub = 1; l_lb = 1; l_addr = 7; l_wdata = 16'h4321; cycle("R7");
        lread(7, 1, 1); cycle("R7");
        r_we = 1; r_addr = BOX_L; r_ub = 1; r_lb = 1; r_wdata = 16'hFFFF; cycle("R7");
        // R3: opposite-side read during write
        lwrite(9, 16'hC0DE, 1, 1); rread(9); cycle("R3");
        rread(9); cycle("R3");
        // R4, R10, R5
        rwrite(BOX_L, 16'hD00D); cycle("R4");
        lread(BOX_L, 1, 1); cycle("R10");
        rwrite(BOX_L, 16'hBEEF); cycle("R4");
        lread(BOX_L, 1, 1); l_we = 1; l_wdata = 16'h7777; cycle("R5");
        lread(BOX_L, 1, 1); cycle("R10");
        // R6
        lwrite(BOX_R, 16'h0F0F, 1, 1); cycle("R6");
        rread(BOX_R); cycle("R6");
        // R8
        rwrite(BOX_L, 16'h1111); r_busy = 1; cycle("R8");
        lread(BOX_L, 1, 1); cycle("R8");
        rwrite(BOX_L, 16'h2222); cycle("R8");
        lread(BOX_L, 1, 1); l_busy = 1; cycle("R8");
        // R9: set and clear together, read sees old data
        rwrite(BOX_L, 16'h3333); lread(BOX_L, 1, 1); cycle("R9");
        lwrite(BOX_R, 16'h4444, 1, 1); rread(BOX_R); cycle("R9");

        // random phase
        for (int i = 0; i < 4000; i++) begin
            l_en = $urandom_range(0, 3) != 0; l_we = $urandom_range(0, 1);
            l_oe = $urandom_range(0, 3) != 0; l_ub = $urandom_range(0, 3) != 0;
            l_lb = $urandom_range(0, 3) != 0; l_busy = $urandom_range(0, 5) == 0;
            r_en = $urandom_range(0, 3) != 0; r_we = $urandom_range(0, 1);
            r_oe = $urandom_range(0, 3) != 0; r_ub = $urandom_range(0, 3) != 0;
            r_lb = $urandom_range(0, 3) != 0; r_busy = $urandom_range(0, 5) == 0;
            l_addr = ($urandom_range(0, 1) != 0) ? AW'(DEPTH - 1 - $urandom_range(0, 3))
                                                 : AW'($urandom);
            r_addr = ($urandom_range(0, 1) != 0) ? AW'(DEPTH - 1 - $urandom_range(0, 3))
                                                 : AW'($urandom);
            l_wdata = DW'($urandom); r_wdata = DW'($urandom);
            if (l_en && l_we && r_en && r_we && l_addr == r_addr) r_we = 0;
            cycle("R2");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule